// File: doc/BRIEF.md
# Smoothed Stereo Digital Attenuator with Mutes

This block scales a stream of 16-bit two's-complement stereo samples by a gain that never jumps during normal level changes. The gain is a 9-bit counter running from 0 to 256, where 256 means unity (0 dB). The counter walks one step toward its target on every fourth frame, so an attenuation change produces no audible click. It takes a new target on the fly: a change that arrives halfway through a ramp turns the ramp from wherever the counter stands.

The block also has three ways to silence the output. Soft mute drives the gain counter down to zero. When soft mute is released, the gain returns to its target at once. Forced mute zeroes the output samples without touching the gain. It has three sources: a command flag, a pin, and an empty valid-data buffer while the memory system is on. Forced mute switches only at the start of a left-channel sample, so a stereo pair is never split.

A sample arrives as a one-cycle strobe with a left/right indicator. Its scaled result appears one clock later with a one-cycle valid pulse.

Top module: `smooth_attenuator`

## Requirements
- R1: After reset, gainLevel is 256, outValid is 0 and sampleOut is 0.
- R2: A strobe (sampleValid=1) produces outValid=1 for exactly the next cycle. In that cycle, sampleOut = floor(sampleIn × g / 256), where g is the gainLevel value present during the strobe cycle. Without a strobe, outValid is 0.
- R3: The ramp target is attLevel when attEnable=1, and 256 when attEnable=0 (unity, output equals input).
- R4: A frame tick is a strobe with sampleLeft=1. The gain moves by exactly one toward its target on every fourth frame tick counted since reset, and at no other time except a soft-mute release. Eight consecutive frames therefore move it by exactly two steps while it is short of its target.
- R5: A target that changes while a ramp is in progress is approached from the current gain, without a jump.
- R6: While softMute=1 the target is 0. A full ramp from 256 therefore reaches zero after exactly 1024 frames and stays at zero, and samples come out as 0.
- R7: On the cycle that follows softMute going from 1 to 0, gainLevel becomes attLevel if attEnable=1, or 256 if attEnable=0.
- R8: forceMuteCmd or forceMutePin makes sampleOut 0. The mute state is sampled only at a frame tick and applies from that left sample on, including its right sample. A change between a left and a right strobe takes effect from the next left sample.
- R9: memOn=1 together with bufEmpty=1 mutes the output in the same frame-aligned way as R8. memOn=1 with bufEmpty=0 does not mute.
- R10: The forced mute ends only at a frame tick where all of its sources are inactive.
- R11: gainLevel never exceeds 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle sample strobe |
| sampleLeft | input | 1 | 1 = the strobed sample is the left channel |
| sampleIn | input | 16 | Input sample, two's complement |
| attLevel | input | 8 | Attenuation level, gain = attLevel/256 |
| attEnable | input | 1 | 1 = attLevel is the target, 0 = unity target |
| softMute | input | 1 | Ramp the gain to zero while high |
| forceMuteCmd | input | 1 | Forced mute request flag |
| forceMutePin | input | 1 | Forced mute request pin |
| memOn | input | 1 | Memory system enabled |
| bufEmpty | input | 1 | Valid-data buffer is empty |
| sampleOut | output | 16 | Scaled output sample |
| outValid | output | 1 | sampleOut updated this cycle |
| gainLevel | output | 9 | Current gain counter, 0 to 256 |

## Verification
The assertions take four things for granted about the inputs:
- softMute is low through reset and during the first cycle after it, so no release is seen at time zero.
- Strobes last one cycle each.
- A left strobe opens every frame.
- The mute sources are steady around the left strobe they affect.

The stimulus changes inputs only on the falling clock edge. Each frame is a left strobe, a right strobe and an idle cycle. The bench moves a mute source between the two strobes of a frame only on purpose, to test the frame alignment.

// File: rtl/att_pkg.sv
`timescale 1ns/1ps
package att_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;  // register a new output sample
    logic zero;  // force the registered sample to zero
  } dpCtrl_t;
endpackage

// File: rtl/att_ctrl.sv
`timescale 1ns/1ps
module att_ctrl
  import att_pkg::*;
#(
  parameter int ATT_W      = 8,
  parameter int STEP_TICKS = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleValid,
  input  logic           sampleLeft,
  input  logic [ATT_W-1:0] attLevel,
  input  logic           attEnable,
  input  logic           softMute,
  input  logic           forceMuteCmd,
  input  logic           forceMutePin,
  input  logic           memOn,
  input  logic           bufEmpty,
  output dpCtrl_t        dpCtrl,
  output logic [ATT_W:0] gain
);
  localparam int GAIN_W = ATT_W + 1;
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << ATT_W);

  logic [GAIN_W-1:0] relTarget;
  logic [GAIN_W-1:0] rampTarget;
  logic              frameTick;
  logic              stepNow;
  logic              releaseNow;
  logic              muteSrc;
  logic              forceHeld;
  logic              softPrev;

  assign frameTick  = sampleValid & sampleLeft;
  assign relTarget  = attEnable ? {1'b0, attLevel} : UNITY;
  assign rampTarget = softMute ? '0 : relTarget;
  assign releaseNow = softPrev & ~softMute;
  assign muteSrc    = forceMuteCmd | forceMutePin | (memOn & bufEmpty);

  // Step pacing: every STEP_TICKS frame ticks
  generate
    if (STEP_TICKS <= 1) begin : g_everyTick
      assign stepNow = frameTick;
    end else begin : g_divided
      localparam int PHASE_W = $clog2(STEP_TICKS);
      localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(STEP_TICKS - 1);
      logic [PHASE_W-1:0] phase;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          phase <= '0;
        end else if (frameTick) begin
          phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
        end
      end
      assign stepNow = frameTick && (phase == LAST_PHASE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gain      <= UNITY;
      forceHeld <= 1'b0;
      softPrev  <= 1'b0;
    end else begin
      softPrev <= softMute;
      if (frameTick) forceHeld <= muteSrc;
      if (releaseNow) begin
        gain <= relTarget;
      end else if (stepNow) begin
        if (gain < rampTarget)      gain <= gain + 1'b1;
        else if (gain > rampTarget) gain <= gain - 1'b1;
      end
    end
  end

  // A left sample sees the freshly sampled mute sources; a right sample the held state
  always_comb begin
    dpCtrl.load = sampleValid;
    dpCtrl.zero = frameTick ? muteSrc : forceHeld;
  end
endmodule

// File: rtl/att_dp.sv
`timescale 1ns/1ps
module att_dp
  import att_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ATT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  dpCtrl,
  input  logic [ATT_W:0]           gain,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     outValid
);
  localparam int PROD_W = DATA_W + ATT_W + 2;

  logic signed [ATT_W+1:0]  gainS;
  logic signed [PROD_W-1:0] inExt;
  logic signed [PROD_W-1:0] gainExt;
  logic signed [PROD_W-1:0] prod;
  logic signed [DATA_W-1:0] scaled;
  logic [ATT_W-1:0]         unusedLowBits;
  logic [PROD_W-ATT_W-DATA_W-1:0] unusedHighBits;

  assign gainS   = $signed({1'b0, gain});
  assign inExt   = PROD_W'(sampleIn);
  assign gainExt = PROD_W'(gainS);
  assign prod    = inExt * gainExt;
  // Dropping the low bits of a two's-complement product floors toward minus infinity
  assign scaled  = prod[ATT_W +: DATA_W];
  assign unusedLowBits  = prod[ATT_W-1:0];
  assign unusedHighBits = prod[PROD_W-1:ATT_W+DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= dpCtrl.load;
      if (dpCtrl.load) sampleOut <= dpCtrl.zero ? '0 : scaled;
    end
  end
endmodule

// File: rtl/smooth_attenuator.sv
`timescale 1ns/1ps
module smooth_attenuator
  import att_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ATT_W      = 8,
  parameter int STEP_TICKS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic                     sampleLeft,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [ATT_W-1:0]         attLevel,
  input  logic                     attEnable,
  input  logic                     softMute,
  input  logic                     forceMuteCmd,
  input  logic                     forceMutePin,
  input  logic                     memOn,
  input  logic                     bufEmpty,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     outValid,
  output logic [ATT_W:0]           gainLevel
);
  dpCtrl_t dpCtrl;

  att_ctrl #(.ATT_W(ATT_W), .STEP_TICKS(STEP_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleLeft(sampleLeft),
    .attLevel(attLevel), .attEnable(attEnable), .softMute(softMute),
    .forceMuteCmd(forceMuteCmd), .forceMutePin(forceMutePin),
    .memOn(memOn), .bufEmpty(bufEmpty), .dpCtrl(dpCtrl), .gain(gainLevel)
  );

  att_dp #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .gain(gainLevel),
    .sampleIn(sampleIn), .sampleOut(sampleOut), .outValid(outValid)
  );
endmodule

// File: rtl/att_chk.sv
`timescale 1ns/1ps
module att_chk #(
  parameter int DATA_W = 16,
  parameter int ATT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              sampleLeft,
  input logic              softMute,
  input logic              forceMuteCmd,
  input logic              forceMutePin,
  input logic              memOn,
  input logic              bufEmpty,
  input logic [DATA_W-1:0] sampleOut,
  input logic              outValid,
  input logic [ATT_W:0]    gainLevel
);
  localparam int UNITY = 1 << ATT_W;

  // R11
  gain_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(gainLevel) <= UNITY);

  // R4
  gain_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !($past(softMute) && !softMute) |=>
      ((int'(gainLevel) - int'($past(gainLevel)) <= 1) &&
       (int'($past(gainLevel)) - int'(gainLevel) <= 1)));

  // R4
  gain_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(sampleValid && sampleLeft) && !($past(softMute) && !softMute)) |=> $stable(gainLevel));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid);

  // R8
  force_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleLeft && (forceMuteCmd || forceMutePin)) |=> (sampleOut == '0));

  // R9
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleLeft && memOn && bufEmpty) |=> (sampleOut == '0));

  // R6
  soft_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (softMute && gainLevel == '0) |=> (gainLevel == '0));
endmodule

bind smooth_attenuator att_chk #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleLeft(sampleLeft),
  .softMute(softMute), .forceMuteCmd(forceMuteCmd), .forceMutePin(forceMutePin),
  .memOn(memOn), .bufEmpty(bufEmpty), .sampleOut(sampleOut),
  .outValid(outValid), .gainLevel(gainLevel)
);

// File: tb/sim_smooth_attenuator.sv
`timescale 1ns/1ps
module sim_smooth_attenuator;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0, sampleLeft = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic [7:0] attLevel = 8'd64;
  logic attEnable = 1'b0, softMute = 1'b0, forceMuteCmd = 1'b0, forceMutePin = 1'b0;
  logic memOn = 1'b0, bufEmpty = 1'b0;
  logic signed [15:0] sampleOut;
  logic outValid;
  logic [8:0] gainLevel;

  int errors = 0;
  int checks = 0;
  int gotL, gotR;
  bit finished = 0;

  always #2.5 clk = ~clk;

  smooth_attenuator u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleLeft(sampleLeft),
    .sampleIn(sampleIn), .attLevel(attLevel), .attEnable(attEnable),
    .softMute(softMute), .forceMuteCmd(forceMuteCmd), .forceMutePin(forceMutePin),
    .memOn(memOn), .bufEmpty(bufEmpty), .sampleOut(sampleOut),
    .outValid(outValid), .gainLevel(gainLevel)
  );

  // Behavioural reference model, updated on each rising edge
  int mGain = 256, mPhase = 0, mOut = 0;
  bit mValid = 0, mForce = 0, mSoftPrev = 0;

  always @(posedge clk) begin
    int tgtRel, tgtRamp, src;
    bit tick;
    if (!rstN) begin
      mGain = 256; mPhase = 0; mOut = 0; mValid = 0; mForce = 0; mSoftPrev = 0;
    end else begin
      tgtRel  = attEnable ? int'(attLevel) : 256;
      tgtRamp = softMute ? 0 : tgtRel;
      src     = int'(forceMuteCmd | forceMutePin | (memOn & bufEmpty));
      tick    = sampleValid && sampleLeft;
      mValid  = sampleValid;
      if (sampleValid) begin
        if (tick) mForce = (src != 0);
        mOut = mForce ? 0 : ((int'(sampleIn) * mGain) >>> 8);
      end
      if (mSoftPrev && !softMute) mGain = tgtRel;
      else if (tick && mPhase == 3) begin
        if (mGain < tgtRamp) mGain = mGain + 1;
        else if (mGain > tgtRamp) mGain = mGain - 1;
      end
      if (tick) mPhase = (mPhase + 1) % 4;
      mSoftPrev = softMute;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(int'(gainLevel) == mGain, "R4 gainLevel vs model", int'(gainLevel), mGain);
      check(outValid == mValid, "R2 outValid vs model", int'(outValid), int'(mValid));
      if (mValid) check(int'(sampleOut) == mOut, "R2 sampleOut vs model", int'(sampleOut), mOut);
      check(int'(gainLevel) <= 256, "R11 gain bound", int'(gainLevel), 256);
    end
  end

  // One frame; midPin is applied to forceMutePin between the left and right strobes
  task automatic frameMid(input int l, input int r, input bit changePin, input bit midPin);
    @(negedge clk);
    sampleValid = 1; sampleLeft = 1; sampleIn = 16'(l);
    @(negedge clk);
    gotL = int'(sampleOut);
    if (changePin) forceMutePin = midPin;
    sampleLeft = 0; sampleIn = 16'(r);
    @(negedge clk);
    gotR = int'(sampleOut);
    sampleValid = 0;
  endtask

  task automatic frame(input int l, input int r);
    frameMid(l, r, 0, 0);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) frame(100, -100);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(gainLevel == 9'd256, "R1 reset gain", int'(gainLevel), 256);
    check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    check(sampleOut == 16'sd0, "R1 reset sampleOut", int'(sampleOut), 0);
    rstN = 1;
    @(negedge clk);

    frame(1000, -1000);
    check(gotL == 1000, "R2 unity left", gotL, 1000);
    check(gotR == -1000, "R2 unity right", gotR, -1000);

    attLevel = 8'd64; attEnable = 1;
    frames(8);
    check(int'(gainLevel) == 254, "R4 two steps in eight frames", int'(gainLevel), 254);
    frames(800);
    check(int'(gainLevel) == 64, "R3 target is attLevel", int'(gainLevel), 64);
    frame(16384, -3);
    check(gotL == 4096, "R2 scaled left", gotL, 4096);
    check(gotR == -1, "R2 floor of negative", gotR, -1);

    attLevel = 8'd0;
    frames(100);
    check(int'(gainLevel) == 39, "R4 ramp down 25 steps", int'(gainLevel), 39);
    attLevel = 8'd100;
    frames(8);
    check(int'(gainLevel) == 41, "R5 retarget continues from current", int'(gainLevel), 41);
    frames(300);
    check(int'(gainLevel) == 100, "R5 reaches newest target", int'(gainLevel), 100);

    attEnable = 0;
    frames(700);
    check(int'(gainLevel) == 256, "R3 disabled targets unity", int'(gainLevel), 256);

    softMute = 1;
    frames(1016);
    check(int'(gainLevel) == 2, "R6 soft ramp after 1016 frames", int'(gainLevel), 2);
    frames(8);
    check(int'(gainLevel) == 0, "R6 soft ramp done at 1024 frames", int'(gainLevel), 0);
    frame(12345, -12345);
    check(gotL == 0 && gotR == 0, "R6 soft mute output zero", gotL, 0);

    attEnable = 1; attLevel = 8'd100;
    frames(4);
    check(int'(gainLevel) == 0, "R6 soft mute holds zero", int'(gainLevel), 0);
    softMute = 0;
    @(negedge clk);
    check(int'(gainLevel) == 100, "R7 release jumps to attLevel", int'(gainLevel), 100);

    forceMuteCmd = 1;
    frame(5000, 5000);
    check(gotL == 0 && gotR == 0, "R8 command mute", gotL, 0);
    forceMuteCmd = 0;
    frame(5000, 5000);
    check(gotL == 1953, "R8 command mute ended", gotL, 1953);
    frameMid(5000, 5000, 1, 1);
    check(gotR == 1953, "R8 pin rising mid-frame waits for left", gotR, 1953);
    frameMid(5000, 5000, 1, 0);
    check(gotL == 0, "R8 pin mute at left", gotL, 0);
    check(gotR == 0, "R8 pin falling mid-frame holds right muted", gotR, 0);
    frame(5000, 5000);
    check(gotL == 1953, "R8 pin mute ended at left", gotL, 1953);

    memOn = 1; bufEmpty = 0;
    frame(5000, 5000);
    check(gotL == 1953, "R9 memOn alone not muted", gotL, 1953);
    bufEmpty = 1;
    frame(5000, 5000);
    check(gotL == 0 && gotR == 0, "R9 empty buffer mutes", gotL, 0);

    forceMuteCmd = 1;
    frame(5000, 5000);
    bufEmpty = 0;
    frame(5000, 5000);
    check(gotL == 0 && gotR == 0, "R10 one source still active", gotL, 0);
    forceMuteCmd = 0;
    frame(5000, 5000);
    check(gotL == 1953 && gotR == 1953, "R10 all sources inactive", gotL, 1953);
    memOn = 0;

    attEnable = 0; softMute = 1;
    frames(4);
    softMute = 0;
    @(negedge clk);
    check(int'(gainLevel) == 256, "R7 release jumps to unity when disabled", int'(gainLevel), 256);
    frame(-7, 7);
    check(gotL == -7 && gotR == 7, "R3 unity after release", gotL, -7);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule